// File: doc/BRIEF.md
# Tape Controller Command and Status Interface

This block is the host-facing register pair of a controller that serves up to eight magnetic tape drives. The host issues one I/O operation per cycle as a six-bit operation code with an 18-bit accumulator word. Each code does one of the following:

- tests a condition and returns a skip indication;
- reads back the command word or the status word;
- clears flags;
- loads the command word;
- asks the selected drive to start the function held in the command word.

A start request is screened for illegal conditions. A rejected request raises the illegal flag. An accepted request produces a one-cycle start strobe toward the drive data path.

The drives themselves are outside the block. They are represented by four per-drive level inputs: active, attached, write-protected and at position zero. They also feed a completion event stream. The block keeps four marks per drive: rewinding, beginning-of-tape, file mark seen and end-of-tape. The marks of the drive named in the command word are merged with the controller's own error flags to form the status word. The interrupt request follows that word.

The completion stream is a valid-only stream: `done_valid` qualifies `done_unit`, `done_flags` and `done_mark` for one cycle. The block accepts every event in the cycle it arrives and never applies back-pressure.

Top module: `tape_ctl_if`

## Requirements
- R1: After reset the command word, all controller flags and all drive marks are zero, so command and status reads return 0 and `irq` is low.
- R2: The command word has these fields: unit in bits 17:15, parity select at bit 14, dump at bit 13, long gap at bit 12, function in bits 11:9, interrupt enable at bit 8, and drive type in bits 7:6. An operation code with `(code & 064) == 024` replaces the command word with `(cmd & 0770700) | (acc & 0777700)`. Bits 5:0 stay zero.
- R3: Read replies are returned on `iot_data` in the same cycle and reflect the state before the operation. Code 002 returns `cmd & 0777700`, code 042 returns the status word, and any other code returns `iot_acc` unchanged.
- R4: The status word has these bits: error 17, rewinding 16, beginning-of-tape 15, illegal 14, parity 13, file mark 12, end-of-tape 11, compare 10, record length 9, data late 8, bad tape 7, done 6. Bits 5:0 read zero.
- R5: The error bit is set exactly when any of beginning-of-tape, illegal, parity, file mark, end-of-tape, compare, record length, data late or bad tape is set.
- R6: Skip results are given in the same cycle. Code 001 skips when the selected drive is not active. Code 021 skips when no active drive lacks the rewinding mark. Code 041 skips when error or done is set.
- R7: An operation code with `(code & 062) == 022` clears done. If no active drive lacks the rewinding mark, it also clears the command word and every controller flag.
- R8: Go (code 004) is rejected and sets illegal in any of these cases: the controller is busy; the selected drive is active; rewind (1) or space reverse (7) is requested at position zero; write (4) or file mark (5) is requested on a write-protected drive; the drive is not attached; or the function is 0.
- R9: An accepted go pulses `start_valid` in the next cycle, with the unit and the function. A rewind sets the drive's rewinding mark and leaves the controller flags as they are. Any other function clears that drive's marks and all controller flags.
- R10: A completion event replaces the marks of `done_unit` with `{0, done_mark}`, where `done_mark` is {beginning-of-tape, file mark, end-of-tape}. If `done_unit` is the selected unit, the event also ORs `done_flags` ({parity, compare, record length, data late, bad tape}) into the flags and sets done.
- R11: The rewinding, beginning-of-tape, file mark and end-of-tape status bits always show the marks of the unit currently named in the command word.
- R12: `irq` is high exactly when error or done is set and the interrupt-enable bit is zero.
- R13: A code that both clears and loads (for example 026) clears first and then loads. A completion event in the same cycle as an operation is applied after the operation, and it is matched against the unit selected before that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iot_strobe | input | 1 | Host operation valid this cycle |
| iot_code | input | 6 | Host operation code |
| iot_acc | input | 18 | Host accumulator word |
| iot_data | output | 18 | Read reply or accumulator pass-through |
| iot_skip | output | 1 | Skip result of a test code |
| drv_active | input | NUM_UNITS | Drive has an operation in progress |
| drv_attached | input | NUM_UNITS | Drive has media mounted |
| drv_wprot | input | NUM_UNITS | Drive is write-protected |
| drv_at_bot | input | NUM_UNITS | Drive is at position zero |
| done_valid | input | 1 | Completion event valid |
| done_unit | input | 3 | Completing drive |
| done_flags | input | 5 | Error flags {parity, compare, length, late, bad} |
| done_mark | input | 3 | New marks {beginning, file mark, end} |
| start_valid | output | 1 | Accepted start, one cycle |
| start_unit | output | 3 | Drive to start |
| start_func | output | 3 | Function to perform |
| irq | output | 1 | Interrupt request |

## Verification
`iot_data` and `iot_skip` are combinational replies, due in the same cycle as the strobe. The bench samples them 1 ns after the falling edge on which it drove the operation, and compares them with a model state that does not yet include that operation. Register effects (new command word, flags, marks, `irq`) and `start_valid` are due one cycle later. They are checked 1 ns after the following rising edge, once the model has committed the same update. Status is observed only through 042 reads in later cycles, so every flag change is checked exactly one cycle after its cause.

// File: rtl/tci_pkg.sv
package tci_pkg;
  localparam int WORD_W = 18;
  localparam int UNIT_W = 3;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_IDLE     = 3'd0,
    FN_REWIND   = 3'd1,
    FN_READ     = 3'd2,
    FN_COMPARE  = 3'd3,
    FN_WRITE    = 3'd4,
    FN_MARK     = 3'd5,
    FN_SKIP_FWD = 3'd6,
    FN_SKIP_REV = 3'd7
  } func_e;

  // per-drive marks
  typedef struct packed {
    logic rew;
    logic bot;
    logic eof;
    logic eot;
  } unit_mark_t;

  // controller-owned flags
  typedef struct packed {
    logic ill;
    logic par;
    logic cmp;
    logic len;
    logic late;
    logic bad;
    logic done;
  } ctl_flags_t;

  localparam logic [5:0] OP_TEST_UNIT = 6'o01;
  localparam logic [5:0] OP_TEST_CTL  = 6'o21;
  localparam logic [5:0] OP_TEST_FLAG = 6'o41;
  localparam logic [5:0] OP_RD_CMD    = 6'o02;
  localparam logic [5:0] OP_RD_STAT   = 6'o42;
  localparam logic [5:0] OP_GO        = 6'o04;
  localparam logic [5:0] CLR_MASK     = 6'o62;
  localparam logic [5:0] CLR_MATCH    = 6'o22;
  localparam logic [5:0] LD_MASK      = 6'o64;
  localparam logic [5:0] LD_MATCH     = 6'o24;

  localparam logic [WORD_W-1:0] CMD_KEEP = 18'o770700;
  localparam logic [WORD_W-1:0] CMD_VIS  = 18'o777700;

  localparam int CMD_UNIT_LSB = 15;
  localparam int CMD_FUNC_LSB = 9;
  localparam int CMD_IE_BIT   = 8;

  function automatic logic [WORD_W-1:0] pack_status(unit_mark_t m, ctl_flags_t f);
    logic err;
    err = m.bot | m.eof | m.eot | f.ill | f.par | f.cmp | f.len | f.late | f.bad;
    return {err, m.rew, m.bot, f.ill, f.par, m.eof, m.eot,
            f.cmp, f.len, f.late, f.bad, f.done, 6'b000000};
  endfunction
endpackage

// File: rtl/tci_cmd_reg.sv
module tci_cmd_reg
  import tci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] cmd
);
  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] nxt;

  always_comb begin
    base = clr_en ? '0 : cmd;
    nxt  = ld_en ? ((base & CMD_KEEP) | (acc & CMD_VIS)) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cmd <= '0;
    else if (clr_en || ld_en) cmd <= nxt;
  end
endmodule

// File: rtl/tci_unit_table.sv
module tci_unit_table
  import tci_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_en,
  input  logic [UNIT_W-1:0]    start_unit,
  input  logic                 start_rew,
  input  logic                 evt_valid,
  input  logic [UNIT_W-1:0]    evt_unit,
  input  logic [2:0]           evt_mark,
  input  logic [UNIT_W-1:0]    sel_unit,
  output unit_mark_t           sel_mark,
  output logic [NUM_UNITS-1:0] rew_vec
);
  unit_mark_t [NUM_UNITS-1:0] marks;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    unit_mark_t mark_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mark_q <= '0;
      else if (evt_valid && evt_unit == UNIT_W'(u))
        mark_q <= '{rew: 1'b0, bot: evt_mark[2], eof: evt_mark[1], eot: evt_mark[0]};
      else if (start_en && start_unit == UNIT_W'(u))
        mark_q <= start_rew ? '{rew: 1'b1, bot: 1'b0, eof: 1'b0, eot: 1'b0} : '0;
    end
    assign marks[u]   = mark_q;
    assign rew_vec[u] = mark_q.rew;
  end

  always_comb begin
    sel_mark = '0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (sel_unit == UNIT_W'(i)) sel_mark = marks[i];
  end
endmodule

// File: rtl/tci_status.sv
module tci_status
  import tci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_done,
  input  logic              clr_all,
  input  logic              set_ill,
  input  logic              start_clear,
  input  logic              evt_hit,
  input  logic [4:0]        evt_flags,
  input  unit_mark_t        sel_mark,
  output logic [WORD_W-1:0] status_word
);
  ctl_flags_t flags_q;
  ctl_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clr_done)    flags_d.done = 1'b0;
    if (clr_all)     flags_d = '0;
    if (set_ill)     flags_d.ill = 1'b1;
    if (start_clear) flags_d = '0;
    if (evt_hit)     flags_d = flags_d | ctl_flags_t'({1'b0, evt_flags, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign status_word = pack_status(sel_mark, flags_q);
endmodule

// File: rtl/tci_go_check.sv
module tci_go_check
  import tci_pkg::*;
(
  input  logic              go_en,
  input  logic [FUNC_W-1:0] func,
  input  logic              ctl_busy,
  input  logic              unit_active,
  input  logic              unit_attached,
  input  logic              unit_wprot,
  input  logic              unit_at_bot,
  output logic              reject,
  output logic              accept
);
  logic backward;
  logic writes;
  logic bad;

  always_comb begin
    backward = (func == FN_REWIND) || (func == FN_SKIP_REV);
    writes   = (func == FN_WRITE) || (func == FN_MARK);
    bad      = ctl_busy || unit_active || (backward && unit_at_bot) ||
               (writes && unit_wprot) || !unit_attached || (func == FN_IDLE);
    reject   = go_en && bad;
    accept   = go_en && !bad;
  end
endmodule

// File: rtl/tape_ctl_if.sv
module tape_ctl_if
  import tci_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iot_strobe,
  input  logic [5:0]           iot_code,
  input  logic [WORD_W-1:0]    iot_acc,
  output logic [WORD_W-1:0]    iot_data,
  output logic                 iot_skip,
  input  logic [NUM_UNITS-1:0] drv_active,
  input  logic [NUM_UNITS-1:0] drv_attached,
  input  logic [NUM_UNITS-1:0] drv_wprot,
  input  logic [NUM_UNITS-1:0] drv_at_bot,
  input  logic                 done_valid,
  input  logic [UNIT_W-1:0]    done_unit,
  input  logic [4:0]           done_flags,
  input  logic [2:0]           done_mark,
  output logic                 start_valid,
  output logic [UNIT_W-1:0]    start_unit,
  output logic [FUNC_W-1:0]    start_func,
  output logic                 irq
);
  logic [WORD_W-1:0]    cmd_q;
  logic [WORD_W-1:0]    stat_word;
  logic [UNIT_W-1:0]    sel_unit;
  logic [FUNC_W-1:0]    cur_func;
  logic [NUM_UNITS-1:0] rew_vec;
  unit_mark_t           sel_mark;
  logic                 ctl_busy;
  logic                 is_clr, is_ld, is_go;
  logic                 go_reject, go_accept;
  logic                 sel_act, sel_att, sel_wp, sel_bot;

  assign sel_unit = cmd_q[CMD_UNIT_LSB +: UNIT_W];
  assign cur_func = cmd_q[CMD_FUNC_LSB +: FUNC_W];
  assign ctl_busy = |(drv_active & ~rew_vec);
  assign is_clr   = iot_strobe && ((iot_code & CLR_MASK) == CLR_MATCH);
  assign is_ld    = iot_strobe && ((iot_code & LD_MASK) == LD_MATCH);
  assign is_go    = iot_strobe && (iot_code == OP_GO);

  always_comb begin
    sel_act = 1'b0;
    sel_att = 1'b0;
    sel_wp  = 1'b0;
    sel_bot = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (sel_unit == UNIT_W'(u)) begin
        sel_act = drv_active[u];
        sel_att = drv_attached[u];
        sel_wp  = drv_wprot[u];
        sel_bot = drv_at_bot[u];
      end
    end
  end

  tci_cmd_reg u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (is_clr && !ctl_busy),
    .ld_en  (is_ld),
    .acc    (iot_acc),
    .cmd    (cmd_q)
  );

  tci_go_check u_go (
    .go_en         (is_go),
    .func          (cur_func),
    .ctl_busy      (ctl_busy),
    .unit_active   (sel_act),
    .unit_attached (sel_att),
    .unit_wprot    (sel_wp),
    .unit_at_bot   (sel_bot),
    .reject        (go_reject),
    .accept        (go_accept)
  );

  tci_unit_table #(.NUM_UNITS(NUM_UNITS)) u_units (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_en   (go_accept),
    .start_unit (sel_unit),
    .start_rew  (cur_func == FN_REWIND),
    .evt_valid  (done_valid),
    .evt_unit   (done_unit),
    .evt_mark   (done_mark),
    .sel_unit   (sel_unit),
    .sel_mark   (sel_mark),
    .rew_vec    (rew_vec)
  );

  tci_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_done    (is_clr),
    .clr_all     (is_clr && !ctl_busy),
    .set_ill     (go_reject),
    .start_clear (go_accept && (cur_func != FN_REWIND)),
    .evt_hit     (done_valid && (done_unit == sel_unit)),
    .evt_flags   (done_flags),
    .sel_mark    (sel_mark),
    .status_word (stat_word)
  );

  always_comb begin
    iot_data = iot_acc;
    iot_skip = 1'b0;
    if (iot_strobe) begin
      unique case (iot_code)
        OP_RD_CMD:    iot_data = cmd_q & CMD_VIS;
        OP_RD_STAT:   iot_data = stat_word;
        OP_TEST_UNIT: iot_skip = !sel_act;
        OP_TEST_CTL:  iot_skip = !ctl_busy;
        OP_TEST_FLAG: iot_skip = stat_word[17] || stat_word[6];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_valid <= 1'b0;
      start_unit  <= '0;
      start_func  <= '0;
    end else begin
      start_valid <= go_accept;
      if (go_accept) begin
        start_unit <= sel_unit;
        start_func <= cur_func;
      end
    end
  end

  assign irq = (stat_word[17] || stat_word[6]) && !cmd_q[CMD_IE_BIT];
endmodule

// File: rtl/tci_checker.sv
module tci_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        iot_strobe,
  input logic [5:0]  iot_code,
  input logic [17:0] iot_acc,
  input logic        done_valid,
  input logic [2:0]  done_unit,
  input logic        start_valid,
  input logic [2:0]  cmd_unit,
  input logic [2:0]  cmd_func,
  input logic        cmd_ie,
  input logic [17:0] stat_word,
  input logic        irq
);
  // R9
  start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> $past(iot_strobe && iot_code == 6'o04));

  // R8
  idle_func_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_strobe && iot_code == 6'o04 && cmd_func == 3'd0) |=> (stat_word[14] && !start_valid));

  // R7
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_strobe && (iot_code & 6'o62) == 6'o22 && !done_valid) |=> !stat_word[6]);

  // R2
  load_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_strobe && (iot_code & 6'o64) == 6'o24) |=> cmd_func == $past(iot_acc[11:9]));

  // R10
  event_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_unit == cmd_unit) |=> stat_word[6]);

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ie |-> !irq);

  // R5
  err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[14]) |-> stat_word[17]);
endmodule

bind tape_ctl_if tci_checker u_tci_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .iot_strobe  (iot_strobe),
  .iot_code    (iot_code),
  .iot_acc     (iot_acc),
  .done_valid  (done_valid),
  .done_unit   (done_unit),
  .start_valid (start_valid),
  .cmd_unit    (cmd_q[17:15]),
  .cmd_func    (cmd_q[11:9]),
  .cmd_ie      (cmd_q[8]),
  .stat_word   (stat_word),
  .irq         (irq)
);

// File: tb/test_tape_ctl_if.sv
`timescale 1ns/1ps
module test_tape_ctl_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iot_strobe = 1'b0;
  logic [5:0]  iot_code = '0;
  logic [17:0] iot_acc = '0;
  logic [17:0] iot_data;
  logic        iot_skip;
  logic [7:0]  drv_active = '0, drv_attached = '1, drv_wprot = '0, drv_at_bot = '0;
  logic        done_valid = 1'b0;
  logic [2:0]  done_unit = '0;
  logic [4:0]  done_flags = '0;
  logic [2:0]  done_mark = '0;
  logic        start_valid;
  logic [2:0]  start_unit, start_func;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [17:0] m_cmd = '0;
  logic [6:0]  m_fl = '0;           // {ill,par,cmp,len,late,bad,done}
  logic [3:0]  m_mk [8];            // {rew,bot,eof,eot}

  always #2 clk = ~clk;

  tape_ctl_if #(.NUM_UNITS(8)) i_tape_ctl_if (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %o expected %o", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_status();
    logic [3:0] mk;
    logic err;
    mk  = m_mk[m_cmd[17:15]];
    err = mk[2] | mk[1] | mk[0] | (|m_fl[6:1]);
    return {err, mk[3], mk[2], m_fl[6], m_fl[5], mk[1], mk[0],
            m_fl[4], m_fl[3], m_fl[2], m_fl[1], m_fl[0], 6'b0};
  endfunction

  task automatic cyc(input logic s, input logic [5:0] c, input logic [17:0] a,
                     input logic ev, input logic [2:0] eu, input logic [4:0] ef,
                     input logic [2:0] em, input string req);
    logic [2:0] sel, fn;
    logic [17:0] st, ed, nc;
    logic busy, es, ill, esv, eirq;
    logic [6:0] nf;
    logic [3:0] nmk [8];
    @(negedge clk);
    iot_strobe = s; iot_code = c; iot_acc = a;
    done_valid = ev; done_unit = eu; done_flags = ef; done_mark = em;
    #1;
    sel = m_cmd[17:15];
    fn  = m_cmd[11:9];
    st  = exp_status();
    busy = 1'b0;
    for (int u = 0; u < 8; u++) if (drv_active[u] && !m_mk[u][3]) busy = 1'b1;
    if (s) begin
      ed = (c == 6'o02) ? (m_cmd & 18'o777700) : (c == 6'o42) ? st : a;
      es = (c == 6'o01) ? !drv_active[sel] : (c == 6'o21) ? !busy :
           (c == 6'o41) ? (st[17] | st[6]) : 1'b0;
      chk(iot_data === ed, req, "data", iot_data, ed);
      chk(iot_skip === es, req, "skip", {17'b0, iot_skip}, {17'b0, es});
    end
    nc = m_cmd; nf = m_fl; esv = 1'b0;
    for (int u = 0; u < 8; u++) nmk[u] = m_mk[u];
    if (s && (c & 6'o62) == 6'o22) begin
      nf[0] = 1'b0;
      if (!busy) begin nc = '0; nf = '0; end
    end
    if (s && (c & 6'o64) == 6'o24) nc = (nc & 18'o770700) | (a & 18'o777700);
    if (s && c == 6'o04) begin
      ill = busy | drv_active[sel] | ((fn == 3'd1 || fn == 3'd7) && drv_at_bot[sel]) |
            ((fn == 3'd4 || fn == 3'd5) && drv_wprot[sel]) | !drv_attached[sel] | (fn == 3'd0);
      if (ill) nf[6] = 1'b1;
      else begin
        esv = 1'b1;
        if (fn == 3'd1) nmk[sel] = 4'b1000;
        else begin nmk[sel] = 4'b0000; nf = '0; end
      end
    end
    if (ev) begin
      nmk[eu] = {1'b0, em};
      if (eu == sel) nf = nf | {1'b0, ef, 1'b1};
    end
    @(posedge clk); #1;
    m_cmd = nc; m_fl = nf;
    for (int u = 0; u < 8; u++) m_mk[u] = nmk[u];
    st = exp_status();
    eirq = (st[17] | st[6]) & ~m_cmd[8];
    chk(irq === eirq, req, "irq R12", {17'b0, irq}, {17'b0, eirq});
    chk(start_valid === esv, req, "start_valid R9", {17'b0, start_valid}, {17'b0, esv});
    if (esv) begin
      chk(start_unit === sel, req, "start_unit R9", {15'b0, start_unit}, {15'b0, sel});
      chk(start_func === fn, req, "start_func R9", {15'b0, start_func}, {15'b0, fn});
    end
  endtask

  task automatic op(input logic [5:0] c, input logic [17:0] a, input string req);
    cyc(1'b1, c, a, 1'b0, 3'd0, 5'd0, 3'd0, req);
  endtask

  function automatic logic [17:0] cw(input int unit, input int fn, input bit ie);
    return 18'((unit << 15) | (fn << 9) | (ie ? 18'o400 : 18'o0));
  endfunction

  initial begin : watchdog
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] codes [12];
    codes = '{6'o01, 6'o21, 6'o41, 6'o02, 6'o42, 6'o22, 6'o24, 6'o26, 6'o04, 6'o32, 6'o34, 6'o17};
    for (int u = 0; u < 8; u++) m_mk[u] = 4'b0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    op(6'o42, 18'o0, "R1");
    op(6'o02, 18'o0, "R1");
    // R2 load, R8 go with idle function
    op(6'o24, cw(2, 0, 0) | 18'o000077, "R2");
    op(6'o02, 18'o0, "R2");
    op(6'o04, 18'o0, "R8");
    op(6'o42, 18'o0, "R4 R5");
    op(6'o41, 18'o0, "R6");
    // R7 idle clear
    op(6'o22, 18'o0, "R7");
    op(6'o02, 18'o0, "R7");
    // R8 rewind at position zero
    drv_at_bot[3] = 1'b1;
    op(6'o24, cw(3, 1, 0), "R2");
    op(6'o04, 18'o0, "R8");
    op(6'o22, 18'o0, "R7");
    drv_at_bot[3] = 1'b0;
    // R9 accepted rewind, R11 rewinding shown
    op(6'o24, cw(3, 1, 0), "R2");
    op(6'o04, 18'o0, "R9");
    drv_active[3] = 1'b1;
    op(6'o42, 18'o0, "R11");
    op(6'o21, 18'o0, "R6");
    op(6'o01, 18'o0, "R6");
    op(6'o22, 18'o0, "R7");
    op(6'o42, 18'o0, "R11");
    // R8 write on protected drive
    drv_wprot[5] = 1'b1;
    op(6'o24, cw(5, 4, 0), "R2");
    op(6'o04, 18'o0, "R8");
    op(6'o26, cw(3, 0, 0), "R13");
    op(6'o42, 18'o0, "R11");
    // R10 rewind completion on selected unit
    drv_active[3] = 1'b0;
    cyc(1'b0, 6'o0, 18'o0, 1'b1, 3'd3, 5'b00000, 3'b100, "R10");
    op(6'o42, 18'o0, "R10");
    op(6'o24, 18'o400, "R12");
    op(6'o22, 18'o0, "R7");
    // busy controller: go rejected, clear keeps command
    drv_active[4] = 1'b1;
    op(6'o24, cw(0, 2, 0), "R2");
    op(6'o04, 18'o0, "R8");
    op(6'o22, 18'o0, "R7");
    op(6'o02, 18'o0, "R3 R7");
    op(6'o42, 18'o0, "R7");
    op(6'o21, 18'o0, "R6");
    drv_active[4] = 1'b0;
    // unattached, space reverse at zero, accepted compare clears flags
    drv_attached[6] = 1'b0;
    op(6'o26, cw(6, 2, 0), "R13");
    op(6'o04, 18'o0, "R8");
    drv_at_bot[1] = 1'b1;
    op(6'o26, cw(1, 7, 0), "R13");
    op(6'o04, 18'o0, "R8");
    op(6'o26, cw(1, 3, 0), "R13");
    op(6'o04, 18'o0, "R9");
    op(6'o42, 18'o0, "R9");
    // R10 event for another unit, then select it
    cyc(1'b0, 6'o0, 18'o0, 1'b1, 3'd2, 5'b10110, 3'b011, "R10");
    op(6'o42, 18'o0, "R10");
    op(6'o26, cw(2, 0, 0), "R11");
    op(6'o42, 18'o0, "R11 R5");
    // R13 event in the same cycle as a clear
    cyc(1'b1, 6'o22, 18'o0, 1'b1, 3'd2, 5'b00001, 3'b000, "R13");
    op(6'o42, 18'o0, "R13");
    op(6'o17, 18'o123456, "R3");
    drv_attached = '1; drv_at_bot = '0; drv_wprot = '0;
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] c;
      logic [17:0] a;
      if ($urandom_range(0, 15) == 0) drv_active   = 8'($urandom) & 8'($urandom);
      if ($urandom_range(0, 15) == 0) drv_attached = 8'($urandom) | 8'($urandom);
      if ($urandom_range(0, 15) == 0) drv_wprot    = 8'($urandom);
      if ($urandom_range(0, 15) == 0) drv_at_bot   = 8'($urandom) & 8'($urandom);
      c = codes[$urandom_range(0, 11)];
      a = 18'($urandom);
      cyc($urandom_range(0, 3) != 0, c, a, $urandom_range(0, 5) == 0,
          3'($urandom), 5'($urandom) & 5'($urandom), 3'($urandom), "R3 R6 R8 R10");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule